// File: doc/BRIEF.md
# Modem Control Register Front End on a Multiplexed Bus

This block connects a modem controller's register file to an 8-bit bus that carries both address and data. A host cycle begins with the address strobe. When that strobe falls, the block captures a 3-bit register address from the low bus lines and records the chip-select level at the same moment. After that, an active-low read strobe or write strobe moves one byte between the bus and the addressed register. The register file holds four control registers, a tone register and a read-only detect register. The detect register collects event pulses from the modem datapath.

Any pending detect bit asserts an open-drain interrupt. The interrupt stays asserted until the host finishes a read of the detect register. One control bit picks the source of the clock output: the crystal clock or a 16x data-rate clock. That bit takes effect only while the QAM/DPSK mode bit is set. If the host holds the address strobe high and the chip-select low, the block switches to a serial mode. In that mode, bit 7 of the bus carries the data one bit at a time, and the low three bus lines carry the register address.

The bus is modelled as an input vector, an output vector and one output-enable. The interrupt is modelled as an active-low pull-down enable. All strobes are sampled on the system clock and treated as already synchronous.

Top module: `mdm_bus_if`

## Requirements
- R1: The register address (bus bits 2:0) and the chip-select level are captured in the cycle where the address strobe is first seen low after being high. Later changes on the bus or chip-select do not affect the access until the next falling edge of the address strobe.
- R2: In parallel mode, `ad_oe` is 1 only while `rd_n` is low and the latched chip-select is low. While it is 1, `ad_out` carries the addressed register.
- R3: In parallel mode, the bus byte is written into the addressed register in the cycle where `wr_n` is first seen high after being low, provided the latched chip-select is low. With the latched chip-select high, nothing is written.
- R4: Register map: addresses 0 to 3 are control registers 0 to 3, address 4 is the detect register, and address 5 is the tone register. Writes to address 4 are ignored. Addresses 6 and 7 read as zero and ignore writes.
- R5: Every nonzero bit of `det_ev` sets the matching detect bit, and that bit stays set. `int_drv_n` is 0 whenever any detect bit is set and 1 otherwise.
- R6: A read of address 4 clears all detect bits in the cycle where the read strobe rises. An event bit that arrives in that same cycle is kept.
- R7: A cycle with `rst` high clears all control registers, the tone register and the detect register, leaving `clk_sel` at 0 and `int_drv_n` at 1.
- R8: `clk_sel` is 1 (16x clock) only when control register 3 bit 0 is 1 and control register 0 bit 4 (QAM/DPSK mode) is 1. Otherwise it is 0 (crystal clock).
- R9: Serial mode holds while the address strobe is high and the chip-select is low. In this mode, each rising edge of `wr_n` shifts bus bit 7 in, least significant bit first. After the 8th bit, the assembled byte is written to the address on bus bits 2:0. Leaving serial mode discards a partial frame.
- R10: In a serial read, the first falling edge of `rd_n` loads the register at bus bits 2:0. While `rd_n` is low, `ad_oe` is 1 and `ad_out[7]` shows the current bit, least significant first. Each rise of `rd_n` advances one bit. The 8th rise ends the frame and, when the frame read address 4, clears the detect register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; falling edge captures address and chip-select |
| cs_n | input | 1 | Active-low chip-select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Bus value seen by the block |
| ad_out | output | 8 | Bus value driven by the block |
| ad_oe | output | 1 | Bus drive enable; 0 means high-impedance |
| det_ev | input | 8 | Detect event pulses, one per bit |
| int_drv_n | output | 1 | Interrupt pull-down enable, active low; 1 releases the line |
| clk_sel | output | 1 | Clock output source: 0 crystal, 1 16x data rate |

## Verification
The assertions check four things on every cycle:
- The bus is never driven without a low read strobe, and in parallel mode never without an active latched chip-select.
- An event always raises the interrupt on the next cycle.
- A pending interrupt only drops after a detect read.
- Reset leaves the interrupt released and the crystal clock selected.

Other behaviours depend on the order of host actions, so only the bench's scenarios can show them:
- address latching that ignores later bus changes;
- writes ignored at addresses 4, 6 and 7;
- a write blocked by an inactive chip-select;
- an event that coincides with the clearing read;
- the gating of the clock select by the mode bit;
- full 8-bit serial write and read frames.

// File: rtl/mdm_bus_pkg.sv
package mdm_bus_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_CR   = 4;
    localparam int CNT_W    = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(NUM_CR);
    localparam logic [ADDR_W-1:0] A_TONE = ADDR_W'(NUM_CR + 1);

    localparam int CLKSEL_CR  = 3;
    localparam int CLKSEL_BIT = 0;
    localparam int QAM_CR     = 0;
    localparam int QAM_BIT    = 4;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic is_writable(input logic [ADDR_W-1:0] a);
        return (int'(a) < NUM_CR) || (a == A_TONE);
    endfunction
endpackage

// File: rtl/mdm_bus_front.sv
module mdm_bus_front
    import mdm_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr_req,
    output logic              det_clr,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              cs_lat
);
    logic              ale_d, rd_d, wr_d;
    logic [ADDR_W-1:0] addr_q;
    logic              cs_q;
    logic              serial, ale_fall, wr_rise, rd_rise, rd_fall;
    logic [DATA_W-1:0] wsh, rsh;
    logic [CNT_W-1:0]  wcnt, rcnt;
    logic [ADDR_W-1:0] raddr_s;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    assign serial   = ale & ~cs_n;
    assign ale_fall = ale_d & ~ale;
    assign wr_rise  = wr_n & ~wr_d;
    assign rd_rise  = rd_n & ~rd_d;
    assign rd_fall  = ~rd_n & rd_d;
    assign cs_lat   = cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_d  <= 1'b1;
            rd_d   <= 1'b1;
            wr_d   <= 1'b1;
            addr_q <= '0;
            cs_q   <= 1'b1;
        end else begin
            ale_d <= ale;
            rd_d  <= rd_n;
            wr_d  <= wr_n;
            if (ale_fall) begin
                addr_q <= ad_in[ADDR_W-1:0];
                cs_q   <= cs_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !serial) begin
            wsh     <= '0;
            wcnt    <= '0;
            rsh     <= '0;
            rcnt    <= '0;
            raddr_s <= '0;
        end else begin
            if (wr_rise) begin
                wsh  <= {ad_in[DATA_W-1], wsh[DATA_W-1:1]};
                wcnt <= wcnt + 1'b1;
            end
            if (rd_fall && rcnt == '0) begin
                rsh     <= rdata;
                raddr_s <= ad_in[ADDR_W-1:0];
            end else if (rd_rise) begin
                rsh  <= rsh >> 1;
                rcnt <= rcnt + 1'b1;
            end
        end
    end

    always_comb begin
        rd_addr = serial ? ad_in[ADDR_W-1:0] : addr_q;
        if (serial) begin
            wr_req.en   = wr_rise && (wcnt == LAST);
            wr_req.addr = ad_in[ADDR_W-1:0];
            wr_req.data = {ad_in[DATA_W-1], wsh[DATA_W-1:1]};
            det_clr     = rd_rise && (rcnt == LAST) && (raddr_s == A_DET);
            ad_oe       = ~rd_n;
            ad_out      = {rsh[0], {(DATA_W-1){1'b0}}};
        end else begin
            wr_req.en   = wr_rise && !cs_q;
            wr_req.addr = addr_q;
            wr_req.data = ad_in;
            det_clr     = rd_rise && !cs_q && (addr_q == A_DET);
            ad_oe       = ~rd_n & ~cs_q;
            ad_out      = rdata;
        end
    end
endmodule

// File: rtl/mdm_reg_bank.sv
module mdm_reg_bank
    import mdm_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] det_ev,
    input  logic              det_clr,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] det_q,
    output logic              clk_sel
);
    logic [DATA_W-1:0] cr_q [NUM_CR];
    logic [DATA_W-1:0] tone_q;
    logic              wr_ok;

    assign wr_ok = wr_req.en && is_writable(wr_req.addr);

    for (genvar i = 0; i < NUM_CR; i++) begin : g_cr
        always_ff @(posedge clk) begin
            if (rst)
                cr_q[i] <= '0;
            else if (wr_ok && wr_req.addr == ADDR_W'(i))
                cr_q[i] <= wr_req.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tone_q <= '0;
            det_q  <= '0;
        end else begin
            if (wr_ok && wr_req.addr == A_TONE)
                tone_q <= wr_req.data;
            det_q <= (det_clr ? '0 : det_q) | det_ev;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CR; i++)
            if (rd_addr == ADDR_W'(i)) rdata = cr_q[i];
        if (rd_addr == A_DET)  rdata = det_q;
        if (rd_addr == A_TONE) rdata = tone_q;
    end

    assign clk_sel = cr_q[CLKSEL_CR][CLKSEL_BIT] & cr_q[QAM_CR][QAM_BIT];
endmodule

// File: rtl/mdm_bus_if.sv
module mdm_bus_if
    import mdm_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] det_ev,
    output logic              int_drv_n,
    output logic              clk_sel
);
    logic [DATA_W-1:0] rdata, det_q;
    logic [ADDR_W-1:0] rd_addr;
    wr_req_t           wr_req;
    logic              det_clr, cs_lat;

    mdm_bus_front u_front (
        .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_in(ad_in), .rdata(rdata), .rd_addr(rd_addr), .wr_req(wr_req),
        .det_clr(det_clr), .ad_out(ad_out), .ad_oe(ad_oe), .cs_lat(cs_lat)
    );

    mdm_reg_bank u_bank (
        .clk(clk), .rst(rst), .wr_req(wr_req), .rd_addr(rd_addr),
        .det_ev(det_ev), .det_clr(det_clr), .rdata(rdata),
        .det_q(det_q), .clk_sel(clk_sel)
    );

    assign int_drv_n = ~|det_q;
endmodule

// File: rtl/mdm_bus_if_chk.sv
module mdm_bus_if_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ale,
    input logic          cs_n,
    input logic          rd_n,
    input logic          ad_oe,
    input logic          cs_lat,
    input logic [DW-1:0] det_ev,
    input logic          det_clr,
    input logic          int_drv_n,
    input logic          clk_sel
);
    // R2
    oe_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !rd_n);
    // R2
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && !(ale && !cs_n)) |-> !cs_lat);
    // R5
    event_raises_int_chk: assert property (@(posedge clk) disable iff (rst)
        (det_ev != '0) |=> !int_drv_n);
    // R5
    int_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!int_drv_n && !det_clr) |=> !int_drv_n);
    // R7
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (int_drv_n && !clk_sel));
endmodule

bind mdm_bus_if mdm_bus_if_chk #(.DW(mdm_bus_pkg::DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .ad_oe(ad_oe),
    .cs_lat(cs_lat), .det_ev(det_ev), .det_clr(det_clr),
    .int_drv_n(int_drv_n), .clk_sel(clk_sel)
);

// File: tb/mdm_bus_if_test.sv
module mdm_bus_if_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst = 1, ale = 0, cs_n = 1, rd_n = 1, wr_n = 1;
    logic [7:0] ad_in = 0, det_ev = 0;
    logic [7:0] ad_out;
    logic       ad_oe, int_drv_n, clk_sel;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    mdm_bus_if uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [7:0] m_reg [8];
    logic [7:0] m_det = 0, m_wsh = 0, m_rsh = 0;
    logic [2:0] m_addr = 0, m_raddr = 0;
    logic       m_cs = 1, p_ale = 1, p_rd = 1, p_wr = 1;
    int         m_wcnt = 0, m_rcnt = 0;

    initial for (int i = 0; i < 8; i++) m_reg[i] = 0;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit ser, clr;
        ser = ale && !cs_n;
        clr = 0;
        if (rst) begin
            for (int i = 0; i < 8; i++) m_reg[i] = 0;
            m_det = 0; m_addr = 0; m_cs = 1;
            p_ale = 1; p_rd = 1; p_wr = 1;
            m_wcnt = 0; m_rcnt = 0; m_wsh = 0; m_rsh = 0; m_raddr = 0;
        end else begin
            if (p_ale && !ale) begin m_addr = ad_in[2:0]; m_cs = cs_n; end
            if (!ser) begin
                m_wcnt = 0; m_rcnt = 0; m_wsh = 0; m_rsh = 0; m_raddr = 0;
                if (wr_n && !p_wr && !m_cs && (m_addr < 4 || m_addr == 5))
                    m_reg[m_addr] = ad_in;
                if (rd_n && !p_rd && !m_cs && m_addr == 4) clr = 1;
            end else begin
                if (wr_n && !p_wr) begin
                    m_wsh = {ad_in[7], m_wsh[7:1]};
                    m_wcnt++;
                    if (m_wcnt == 8) begin
                        if (ad_in[2:0] < 4 || ad_in[2:0] == 5) m_reg[ad_in[2:0]] = m_wsh;
                        m_wcnt = 0;
                    end
                end
                if (!rd_n && p_rd && m_rcnt == 0) begin
                    m_rsh = (ad_in[2:0] == 4) ? m_det : m_reg[ad_in[2:0]];
                    m_raddr = ad_in[2:0];
                end else if (rd_n && !p_rd) begin
                    m_rsh = m_rsh >> 1;
                    m_rcnt++;
                    if (m_rcnt == 8) begin
                        if (m_raddr == 4) clr = 1;
                        m_rcnt = 0;
                    end
                end
            end
            m_det = (clr ? 8'h00 : m_det) | det_ev;
            p_ale = ale; p_rd = rd_n; p_wr = wr_n;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        bit ser, e_oe;
        logic [7:0] e_out;
        #2;
        if (!rst && !finished) begin
            ser = ale && !cs_n;
            e_oe = ser ? !rd_n : (!rd_n && !m_cs);
            e_out = ser ? {m_rsh[0], 7'b0} : ((m_addr == 4) ? m_det : m_reg[m_addr]);
            chk("R2", "model ad_oe", {7'b0, ad_oe}, {7'b0, e_oe});
            if (e_oe) chk("R10", "model ad_out", ad_out, e_out);
            chk("R5", "model int_drv_n", {7'b0, int_drv_n}, {7'b0, m_det == 0});
            chk("R8", "model clk_sel", {7'b0, clk_sel},
                {7'b0, m_reg[3][0] & m_reg[0][4]});
        end
    end

    task automatic par_write(input logic [2:0] a, input logic [7:0] d, input logic cs);
        @(negedge clk); ale = 1; ad_in = {5'b0, a}; cs_n = cs;
        @(negedge clk); ale = 0;
        @(negedge clk); cs_n = 1; ad_in = d; wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk); ad_in = 8'h00;
    endtask

    task automatic par_read(input logic [2:0] a, input logic cs, input logic exp_oe,
                            input logic [7:0] exp, input string req);
        @(negedge clk); ale = 1; ad_in = {5'b0, a}; cs_n = cs;
        @(negedge clk); ale = 0;
        @(negedge clk); cs_n = 1; ad_in = 8'h5E; rd_n = 0;
        @(negedge clk); #1;
        chk(req, "parallel read oe", {7'b0, ad_oe}, {7'b0, exp_oe});
        if (exp_oe) chk(req, "parallel read data", ad_out, exp);
        @(negedge clk); rd_n = 1;
        @(negedge clk);
    endtask

    task automatic ser_write(input logic [2:0] a, input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ad_in = {d[i], 4'b0, a}; wr_n = 0;
            @(negedge clk); wr_n = 1;
        end
        @(negedge clk);
    endtask

    task automatic ser_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] got;
        got = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ad_in = {5'b0, a}; rd_n = 0;
            @(negedge clk); #1;
            chk(req, "serial read oe", {7'b0, ad_oe}, 8'h01);
            got[i] = ad_out[7];
            @(negedge clk); rd_n = 1;
        end
        @(negedge clk);
        chk(req, "serial read byte", got, exp);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        // R7 reset state
        chk("R7", "int after reset", {7'b0, int_drv_n}, 8'h01);
        chk("R7", "clk_sel after reset", {7'b0, clk_sel}, 8'h00);
        chk("R2", "oe idle", {7'b0, ad_oe}, 8'h00);

        // R3 / R4 parallel writes and readback
        par_write(3'd0, 8'h10, 0);
        par_write(3'd1, 8'hA5, 0);
        par_write(3'd2, 8'h3C, 0);
        par_write(3'd3, 8'h01, 0);
        par_write(3'd5, 8'h7E, 0);
        @(negedge clk); #1;
        chk("R8", "16x selected with QAM bit", {7'b0, clk_sel}, 8'h01);
        par_read(3'd1, 0, 1, 8'hA5, "R1");   // bus changed after latch
        par_read(3'd2, 0, 1, 8'h3C, "R3");
        par_read(3'd5, 0, 1, 8'h7E, "R4");
        par_write(3'd6, 8'hFF, 0);
        par_read(3'd6, 0, 1, 8'h00, "R4");
        par_write(3'd4, 8'hFF, 0);
        par_read(3'd4, 0, 1, 8'h00, "R4");
        par_write(3'd1, 8'h00, 1);           // inactive chip-select
        par_read(3'd1, 0, 1, 8'hA5, "R3");
        par_read(3'd1, 1, 0, 8'h00, "R2");   // no drive without chip-select

        // R8 gating by mode bit
        par_write(3'd0, 8'h00, 0);
        @(negedge clk); #1;
        chk("R8", "16x blocked without QAM bit", {7'b0, clk_sel}, 8'h00);

        // R5 / R6 detect and interrupt
        @(negedge clk); det_ev = 8'h05;
        @(negedge clk); det_ev = 8'h00; #1;
        chk("R5", "int asserted on event", {7'b0, int_drv_n}, 8'h00);
        @(negedge clk); det_ev = 8'h20;
        @(negedge clk); det_ev = 8'h00;
        repeat (3) @(negedge clk);
        #1 chk("R5", "int held", {7'b0, int_drv_n}, 8'h00);
        par_read(3'd4, 0, 1, 8'h25, "R6");
        #1 chk("R6", "int released after read", {7'b0, int_drv_n}, 8'h01);

        // R6 event coinciding with the clearing read
        par_write(3'd7, 8'h00, 0);
        @(negedge clk); det_ev = 8'h02;
        @(negedge clk); det_ev = 8'h00;
        @(negedge clk); ale = 1; ad_in = 8'h04; cs_n = 0;
        @(negedge clk); ale = 0;
        @(negedge clk); cs_n = 1; rd_n = 0;
        @(negedge clk); #1 chk("R6", "detect read before clear", ad_out, 8'h02);
        @(negedge clk); rd_n = 1; det_ev = 8'h80;
        @(negedge clk); det_ev = 8'h00; #1;
        chk("R6", "coincident event kept", {7'b0, int_drv_n}, 8'h00);
        par_read(3'd4, 0, 1, 8'h80, "R6");
        #1 chk("R6", "int released", {7'b0, int_drv_n}, 8'h01);

        // R9 / R10 serial mode
        @(negedge clk); ale = 1; cs_n = 0;
        ser_write(3'd5, 8'hC3);
        ser_read(3'd5, 8'hC3, "R9");
        ser_read(3'd2, 8'h3C, "R10");
        @(negedge clk); det_ev = 8'h40;
        @(negedge clk); det_ev = 8'h00;
        ser_read(3'd4, 8'h40, "R10");
        #1 chk("R10", "serial detect read clears", {7'b0, int_drv_n}, 8'h01);
        @(negedge clk); ale = 0; cs_n = 1;
        par_read(3'd5, 0, 1, 8'hC3, "R9");

        // R7 reset clears the register file
        par_write(3'd0, 8'h10, 0);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        par_read(3'd2, 0, 1, 8'h00, "R7");
        par_read(3'd5, 0, 1, 8'h00, "R7");
        #1 chk("R7", "clk_sel cleared", {7'b0, clk_sel}, 8'h00);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule